// File: doc/BRIEF.md
# Page Write Collector with In-Page Column Wrap

This block gathers the data bytes of one serial write command into a page-sized staging buffer and, once the command is committed, replays only the bytes that were actually received as single-byte writes toward the non-volatile array. A command starts with an address. The upper address bits select the page and are held for the whole command. The low column bits set where the first byte goes. Each accepted byte lands at the current column, and the column then steps forward and wraps inside the page. If a host streams more bytes than the page holds, later bytes replace earlier ones.

Opcode decoding, protection checks and chip-select timing are handled outside the block. The surrounding control logic tells the block to start a command, to commit it (when chip select rises at a legal point after a whole byte) or to abort it (any other rise). Data bytes arrive on a valid/ready stream. Write-back leaves on a second valid/ready stream. A beat transfers on any clock edge where valid and ready are both high. A producer that raises valid holds valid, address and data unchanged until ready is seen. A consumer may hold ready low for as long as it likes, and the block waits with its current beat. The input stream is only ready while a command is being collected.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy`, `in_ready` and `wr_valid` are all low.
- R2: A `cmd_start` pulse while not busy (and without `cmd_abort`) makes `in_ready` high from the next cycle. The page is latched from `cmd_addr[ADDR_W-1:COL_W]` and the first column from `cmd_addr[COL_W-1:0]`.
- R3: Each accepted byte is stored at the current column, and the column then increments modulo 2^COL_W (32 by default). A column wrap never changes the page: every write-back address carries the page latched at the start.
- R4: When more than 32 bytes are sent, a byte sent to a column already holding one replaces it. Only the last value per column is written back.
- R5: On `cmd_commit` the block raises `busy` and emits one write-back beat per received column, in ascending column order, with `wr_addr = {page, column}` and `wr_data` the buffered byte.
- R6: Columns of the page that received no byte produce no write-back beat, so the array keeps their previous contents. Erased contents are FFh.
- R7: `cmd_abort` while collecting discards the buffer. `in_ready` drops the next cycle, `busy` stays low, and no write-back beat appears.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R9: Each new command starts with an empty buffer. Bytes from an earlier aborted command are never written back.
- R10: While `busy` is high, `in_ready` is low and `cmd_start`, `cmd_commit` and input bytes have no effect on the write-back sequence or on the state after it.
- R11: A commit with no bytes received produces no write-back beat, and `busy` falls again after one cycle.
- R12: A byte accepted in the same cycle as `cmd_commit` is included in the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Begin a new write command (pulse) |
| cmd_addr | input | ADDR_W | Start address: page bits above, first column below |
| cmd_commit | input | 1 | Program the collected bytes (pulse) |
| cmd_abort | input | 1 | Discard the collected bytes (pulse) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | DATA_W | Input byte |
| wr_valid | output | 1 | Write-back beat valid |
| wr_ready | input | 1 | Array accepts the write-back beat |
| wr_addr | output | ADDR_W | Write-back address {page, column} |
| wr_data | output | DATA_W | Write-back byte |
| busy | output | 1 | Write-back in progress |

## Verification
Corruption of the column counter or the page register shows up in the first write-back beat after the next commit, as a wrong `wr_addr` or a gap or duplicate in the ascending column sequence. A stale or miscleared used-column mask shows up at commit as an extra beat (a leaked or untouched column rewritten) or a missing one. The effect on the bench's array image is visible as soon as the page drains. A stuck state machine shows at the ports within a cycle, as `in_ready` overlapping `busy` or `busy` never falling.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PW_IDLE  = 2'd0,
    PW_FILL  = 2'd1,
    PW_DRAIN = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pwb_slots.sv
// Page register, wrapping column counter and per-column byte/used storage.
module pwb_slots #(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic [ADDR_W-1:0]                  load_addr,
  input  logic                               push,
  input  logic [DATA_W-1:0]                  push_data,
  input  logic                               retire_en,
  input  logic [COL_W-1:0]                   retire_col,
  output logic [ADDR_W-COL_W-1:0]            page_o,
  output logic [(1<<COL_W)-1:0]              used_o,
  output logic [(1<<COL_W)-1:0][DATA_W-1:0]  bytes_o
);
  localparam int DEPTH  = 1 << COL_W;
  localparam int PAGE_W = ADDR_W - COL_W;

  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      col_q  <= '0;
    end else if (load) begin
      page_q <= load_addr[ADDR_W-1:COL_W];
      col_q  <= load_addr[COL_W-1:0];
    end else if (push) begin
      col_q  <= col_q + 1'b1;  // wraps inside the page
    end
  end

  assign page_o = page_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              used_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '1;
        used_q <= 1'b0;
      end else if (load) begin
        byte_q <= '1;
        used_q <= 1'b0;
      end else if (push && col_q == COL_W'(g)) begin
        byte_q <= push_data;
        used_q <= 1'b1;
      end else if (retire_en && retire_col == COL_W'(g)) begin
        used_q <= 1'b0;
      end
    end
    assign used_o[g]  = used_q;
    assign bytes_o[g] = byte_q;
  end
endmodule

// File: rtl/pwb_pick.sv
// Lowest-set-bit finder: selects the next column to write back.
module pwb_pick #(
  parameter int COL_W = 5
) (
  input  logic [(1<<COL_W)-1:0] used,
  output logic                  any,
  output logic [COL_W-1:0]      col
);
  localparam int DEPTH = 1 << COL_W;

  always_comb begin
    any = 1'b0;
    col = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!any && used[i]) begin
        any = 1'b1;
        col = COL_W'(i);
      end
    end
  end
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_commit,
  input  logic              cmd_abort,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy
);
  import pwb_pkg::*;
  localparam int DEPTH  = 1 << COL_W;
  localparam int PAGE_W = ADDR_W - COL_W;

  pw_state_e st_q, st_d;

  logic                             load, push, retire;
  logic [PAGE_W-1:0]                page;
  logic [DEPTH-1:0]                 used;
  logic [DEPTH-1:0][DATA_W-1:0]     bytes;
  logic                             any;
  logic [COL_W-1:0]                 pick_col;

  assign in_ready = (st_q == PW_FILL);
  assign busy     = (st_q == PW_DRAIN);
  assign load     = cmd_start && !cmd_abort && (st_q != PW_DRAIN);
  assign push     = in_valid && in_ready && !load && !cmd_abort;
  assign wr_valid = busy && any;
  assign retire   = wr_valid && wr_ready;
  assign wr_addr  = {page, pick_col};
  assign wr_data  = bytes[pick_col];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PW_IDLE:  if (load) st_d = PW_FILL;
      PW_FILL: begin
        if (cmd_abort)       st_d = PW_IDLE;
        else if (cmd_start)  st_d = PW_FILL;
        else if (cmd_commit) st_d = PW_DRAIN;
      end
      PW_DRAIN: if (!any) st_d = PW_IDLE;
      default:  st_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PW_IDLE;
    else        st_q <= st_d;
  end

  pwb_slots #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_addr  (cmd_addr),
    .push       (push),
    .push_data  (in_data),
    .retire_en  (retire),
    .retire_col (pick_col),
    .page_o     (page),
    .used_o     (used),
    .bytes_o    (bytes)
  );

  pwb_pick #(.COL_W(COL_W)) u_pick (
    .used (used),
    .any  (any),
    .col  (pick_col)
  );
endmodule

// File: rtl/page_write_buffer_chk.sv
module page_write_buffer_chk #(
  parameter int ADDR_W = 11,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              cmd_abort,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!busy && !in_ready && !wr_valid));

  // R2
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && !cmd_abort) |=> in_ready);

  // R10
  a_r10_no_fill_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && busy));

  // R5: beats only during write-back
  a_r5_beat_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  // R8
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R5: strictly ascending columns within one drain
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=>
      (!wr_valid || (wr_addr[COL_W-1:0] > $past(wr_addr[COL_W-1:0]))));

  // R3: page never changes inside one drain
  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=>
      (!wr_valid || (wr_addr[ADDR_W-1:COL_W] == $past(wr_addr[ADDR_W-1:COL_W]))));

  // R7
  a_r7_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && cmd_abort) |=> (!in_ready && !busy));
endmodule

bind page_write_buffer page_write_buffer_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .cmd_abort (cmd_abort),
  .in_ready  (in_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .busy      (busy)
);

// File: tb/page_write_buffer_test.sv
`timescale 1ns/1ps
module page_write_buffer_test;
  localparam int ADDR_W = 11;
  localparam int COL_W  = 5;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_commit = 1'b0, cmd_abort = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, wr_valid, busy;
  logic wr_ready = 1'b1;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  always #2 clk = ~clk;

  page_write_buffer #(.ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_commit(cmd_commit), .cmd_abort(cmd_abort), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] arr [2048];
  int log_a[$];
  int log_d[$];
  logic [7:0] m_buf [DEPTH];
  bit m_used [DEPTH];
  int m_page, m_col;

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      log_a.push_back(int'(wr_addr));
      log_d.push_back(int'(wr_data));
      arr[wr_addr] = wr_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_start(input int addr);
    cmd_start = 1'b1; cmd_addr = ADDR_W'(addr);
    tick();
    cmd_start = 1'b0;
    m_page = addr / DEPTH; m_col = addr % DEPTH;
    for (int i = 0; i < DEPTH; i++) begin m_buf[i] = 8'hFF; m_used[i] = 0; end
    log_a.delete(); log_d.delete();
  endtask

  task automatic push(input int d);
    in_valid = 1'b1; in_data = DATA_W'(d);
    tick();
    in_valid = 1'b0;
    m_buf[m_col] = 8'(d); m_used[m_col] = 1; m_col = (m_col + 1) % DEPTH;
  endtask

  task automatic commit();
    cmd_commit = 1'b1;
    tick();
    cmd_commit = 1'b0;
  endtask

  task automatic drain(input bit alternate);
    int guard = 0;
    while (busy && guard < 400) begin
      wr_ready = alternate ? ~wr_ready : 1'b1;
      tick();
      guard++;
    end
    wr_ready = 1'b1;
    repeat (2) tick();
  endtask

  task automatic check_log(input string req);
    int ea[$];
    int ed[$];
    for (int c = 0; c < DEPTH; c++)
      if (m_used[c]) begin ea.push_back(m_page * DEPTH + c); ed.push_back(int'(m_buf[c])); end
    check(log_a.size() == ea.size(), {req, " beat count"}, log_a.size(), ea.size());
    for (int i = 0; i < ea.size() && i < log_a.size(); i++) begin
      check(log_a[i] == ea[i], {req, " addr"}, log_a[i], ea[i]);
      check(log_d[i] == ed[i], {req, " data"}, log_d[i], ed[i]);
    end
  endtask

  task automatic t_reset();
    check(!busy, "R1 busy", busy, 0);
    check(!in_ready, "R1 in_ready", in_ready, 0);
    check(!wr_valid, "R1 wr_valid", wr_valid, 0);
  endtask

  task automatic t_basic();
    do_start('h123);
    check(in_ready, "R2 in_ready after start", in_ready, 1);
    for (int i = 0; i < 5; i++) push('h40 + i);
    commit();
    check(busy, "R5 busy after commit", busy, 1);
    drain(0);
    check_log("R5");
    for (int c = 0; c < DEPTH; c++) begin
      int e = (c >= 3 && c <= 7) ? 'h40 + c - 3 : 'hFF;
      check(arr['h120 + c] == 8'(e), "R6 page image", arr['h120 + c], e);
    end
    do_start('h12A);
    push('h99); push('h9A);
    commit(); drain(0);
    check_log("R6 second command");
    for (int c = 3; c <= 7; c++)
      check(arr['h120 + c] == 8'('h40 + c - 3), "R6 untouched kept", arr['h120 + c], 'h40 + c - 3);
    check(arr['h12A] == 8'h99, "R6 new byte", arr['h12A], 'h99);
  endtask

  task automatic t_wrap();
    do_start('h7FC);
    for (int i = 0; i < 6; i++) push('h10 + i);
    commit(); drain(0);
    check_log("R3 wrap stays in page");
    check(arr['h7E0] == 8'h14, "R3 wrapped column 0", arr['h7E0], 'h14);
    do_start('h0A0);
    for (int i = 0; i < 34; i++) push(i);
    commit(); drain(0);
    check_log("R4 overwrite");
    check(arr['h0A0] == 8'd32, "R4 last value col0", arr['h0A0], 32);
    check(arr['h0A2] == 8'd2, "R4 col2 once", arr['h0A2], 2);
  endtask

  task automatic t_abort();
    do_start('h200);
    push('h55); push('h56); push('h57);
    cmd_abort = 1'b1; tick(); cmd_abort = 1'b0;
    check(!in_ready, "R7 in_ready drops", in_ready, 0);
    repeat (4) begin
      check(!busy && !wr_valid, "R7 no write-back", {busy, wr_valid}, 0);
      tick();
    end
    check(log_a.size() == 0, "R7 no beats", log_a.size(), 0);
    do_start('h205);
    push('h77);
    commit(); drain(0);
    check_log("R9 fresh buffer");
    check(arr['h200] == 8'hFF, "R9 aborted byte not leaked", arr['h200], 'hFF);
  endtask

  task automatic t_backpressure();
    do_start('h300);
    push('hA1); push('hA2); push('hA3);
    wr_ready = 1'b0;
    commit();
    for (int k = 0; k < 3; k++) begin
      check(wr_valid, "R8 valid held", wr_valid, 1);
      check(wr_addr == 11'h300, "R8 addr held", wr_addr, 'h300);
      check(wr_data == 8'hA1, "R8 data held", wr_data, 'hA1);
      tick();
    end
    drain(1);
    check_log("R8 stalled drain");
  endtask

  task automatic t_busy_ignore();
    do_start('h400);
    push('hC0); push('hC1);
    wr_ready = 1'b0;
    commit();
    check(!in_ready, "R10 in_ready low while busy", in_ready, 0);
    cmd_start = 1'b1; cmd_addr = 11'h500; in_valid = 1'b1; in_data = 8'hEE; cmd_commit = 1'b1;
    tick();
    cmd_start = 1'b0; in_valid = 1'b0; cmd_commit = 1'b0;
    drain(0);
    check_log("R10 sequence unchanged");
    check(!in_ready && !busy, "R10 idle afterwards", {in_ready, busy}, 0);
    check(arr['h500] == 8'hFF, "R10 start ignored", arr['h500], 'hFF);
  endtask

  task automatic t_empty();
    do_start('h600);
    commit();
    check(busy, "R11 busy one cycle", busy, 1);
    tick();
    check(!busy, "R11 busy falls", busy, 0);
    drain(0);
    check(log_a.size() == 0, "R11 no beats", log_a.size(), 0);
  endtask

  task automatic t_same_cycle();
    do_start('h710);
    push('h31);
    in_valid = 1'b1; in_data = 8'h32; cmd_commit = 1'b1;
    tick();
    in_valid = 1'b0; cmd_commit = 1'b0;
    m_buf[m_col] = 8'h32; m_used[m_col] = 1; m_col = (m_col + 1) % DEPTH;
    drain(0);
    check_log("R12 byte with commit");
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) arr[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_wrap();
    t_abort();
    t_backpressure();
    t_busy_ignore();
    t_empty();
    t_same_cycle();
    done = 1;
    report();
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      report();
    end
  end
endmodule